// File: doc/BRIEF.md
# Interrupt Pin Request and End-of-Interrupt Delivery Engine

This block is the per-pin request core of an I/O interrupt controller. Interrupt sources report line changes through a strobe per pin that carries the new level. The block keeps a request bit per pin. For each pin it reads the routing fields supplied by a redirection table held elsewhere: vector, destination, destination mode, trigger mode, delivery mode and mask. From these it decides whether the change produces a delivery request, is merged with one already outstanding, or is dropped because the pin is masked. Delivery requests go out one at a time, lowest pin first, over a valid/ready handshake to a downstream arbiter. The arbiter reports with the grant whether at least one destination took the interrupt.

For level-triggered pins the block keeps a remote-acknowledge bit. The bit is set when a delivery reaches at least one destination, and it is cleared by an end-of-interrupt message that names the pin's vector. Every pin whose vector matches is handled by the same message. A level pin whose request is still asserted after its acknowledge clears is delivered again. A per-pin counter of back-to-back re-deliveries detects storms. When the counter reaches its limit, the immediate re-delivery is replaced by a delay timer. When the timer expires, it services every level pin that is still requesting and not awaiting acknowledgement.

Top module: `irq_pin_engine`

## Requirements
- R1: A strobe carrying level 0 clears that pin's request bit, so the pin reads 0 in `irq_snapshot` from the next cycle.
- R2: On an edge-triggered pin (`cfg_trig_level` bit = 0), a strobe with level 1 while the request bit is already set raises `ev_coalesced` for that pin for one cycle and creates no delivery request.
- R3: On a level-triggered pin (`cfg_trig_level` bit = 1), a strobe with level 1 while `remote_irr` is set raises `ev_coalesced` for one cycle and creates no delivery request.
- R4: A service attempt on a pin whose mask bit is 1 raises `ev_masked` for one cycle, and that pin is never presented on the delivery port.
- R5: A grant (`dlv_valid` and `dlv_ready` both 1) of a level-triggered pin with `dlv_hit` = 1 sets that pin's `remote_irr` bit. With `dlv_hit` = 0 the bit stays clear.
- R6: A grant of an edge-triggered pin marks it delivered, and `irq_snapshot` shows the request bits with the delivered pins removed. A later level-1 strobe on that pin clears the delivered mark.
- R7: An end-of-interrupt with `eoi_level` = 1 and `directed_eoi` = 0 clears `remote_irr` on every level-triggered pin whose vector equals `eoi_vector`. When `eoi_level` = 0 or `directed_eoi` = 1, `remote_irr` is left unchanged.
- R8: After R7 clears `remote_irr`, a pin that is unmasked and still requesting is delivered again.
- R9: On the STORM_LIMIT-th back-to-back re-delivery of a pin, the pin is not delivered immediately. Instead `storm_wait` rises, and the pin is presented again exactly DELAY_CYCLES clock edges after the edge that took the end-of-interrupt.
- R10: When the delay timer expires, every level-triggered, unmasked pin with its request set and `remote_irr` clear is queued for delivery.
- R11: Pending pins are offered lowest index first, one grant per cycle. An offer that is not granted stays on the port unchanged.
- R12: After reset, no request, delivered, remote-acknowledge or pending state exists and the delay timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | NPINS | Per-pin line event strobe |
| line_level | input | NPINS | New line level for each strobed pin |
| cfg_vector | input | NPINS*VEC_W | Vector per pin |
| cfg_dest | input | NPINS*DEST_W | Destination per pin |
| cfg_dest_mode | input | NPINS | Destination mode per pin |
| cfg_trig_level | input | NPINS | 1 = level-triggered, 0 = edge-triggered |
| cfg_dlv_mode | input | NPINS*3 | Delivery mode per pin |
| cfg_mask | input | NPINS | 1 = pin masked |
| directed_eoi | input | 1 | 1 = end-of-interrupt messages do not clear remote acknowledge |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | VEC_W | Vector named by the message |
| eoi_level | input | 1 | 1 = message is for a level-triggered interrupt |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Arbiter accepts the request |
| dlv_hit | input | 1 | At least one destination took the granted request |
| dlv_pin | output | PIN_W | Pin being offered |
| dlv_vector | output | VEC_W | Vector of the offered pin |
| dlv_dest | output | DEST_W | Destination of the offered pin |
| dlv_dest_mode | output | 1 | Destination mode of the offered pin |
| dlv_level | output | 1 | Trigger mode of the offered pin |
| dlv_mode | output | 3 | Delivery mode of the offered pin |
| ev_coalesced | output | NPINS | One-cycle pulse: strobe merged with an outstanding request |
| ev_masked | output | NPINS | One-cycle pulse: service dropped because the pin is masked |
| irq_snapshot | output | NPINS | Request bits with delivered edge pins removed |
| remote_irr | output | NPINS | Remote-acknowledge bits |
| storm_wait | output | 1 | Delay timer running |

## Verification
The assertions check on every cycle that a remote-acknowledge bit or a delivered mark appears only after a grant of that pin, that a storm counter stays below its limit, and that the delay timer starts only on the edge that takes an end-of-interrupt. Some behaviour is visible only in the bench scenarios: which strobe merges and which delivers, vector matching across pins, the effect of edge-mode and directed end-of-interrupt messages, the exact delay before storm reinjection, the set of pins served when the timer expires, and the lowest-first order.

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NPINS        = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 2500000,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int CNT_W = $clog2(STORM_LIMIT + 1),
  localparam int TMR_W = $clog2(DELAY_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        line_strobe,
  input  logic [NPINS-1:0]        line_level,
  input  logic [NPINS*VEC_W-1:0]  cfg_vector,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  input  logic [NPINS-1:0]        cfg_dest_mode,
  input  logic [NPINS-1:0]        cfg_trig_level,
  input  logic [NPINS*3-1:0]      cfg_dlv_mode,
  input  logic [NPINS-1:0]        cfg_mask,
  input  logic                    directed_eoi,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic                    eoi_level,
  output logic                    dlv_valid,
  input  logic                    dlv_ready,
  input  logic                    dlv_hit,
  output logic [PIN_W-1:0]        dlv_pin,
  output logic [VEC_W-1:0]        dlv_vector,
  output logic [DEST_W-1:0]       dlv_dest,
  output logic                    dlv_dest_mode,
  output logic                    dlv_level,
  output logic [2:0]              dlv_mode,
  output logic [NPINS-1:0]        ev_coalesced,
  output logic [NPINS-1:0]        ev_masked,
  output logic [NPINS-1:0]        irq_snapshot,
  output logic [NPINS-1:0]        remote_irr,
  output logic                    storm_wait
);

  logic [NPINS-1:0] irr, delivered, pend;
  logic [CNT_W-1:0] cnt [NPINS];
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_on;

  logic [NPINS-1:0] eoi_match, eoi_retry, storm_hit;
  logic [NPINS-1:0] eligible;
  logic             fire, gnt;

  assign fire         = tmr_on && (tmr_cnt == '0);
  assign eligible     = pend & ~cfg_mask;
  assign dlv_valid    = |eligible;
  assign gnt          = dlv_valid && dlv_ready;
  assign irq_snapshot = irr & ~delivered;
  assign storm_wait   = tmr_on;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      eoi_match[i] = eoi_valid && eoi_level && !directed_eoi && cfg_trig_level[i] &&
                     (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);
      eoi_retry[i] = eoi_match[i] && !cfg_mask[i] && irr[i];
      storm_hit[i] = eoi_retry[i] && (cnt[i] == CNT_W'(STORM_LIMIT - 1));
    end
  end

  always_comb begin
    dlv_pin = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (eligible[i]) dlv_pin = PIN_W'(i);
  end

  assign dlv_vector    = cfg_vector[dlv_pin*VEC_W +: VEC_W];
  assign dlv_dest      = cfg_dest[dlv_pin*DEST_W +: DEST_W];
  assign dlv_dest_mode = cfg_dest_mode[dlv_pin];
  assign dlv_level     = cfg_trig_level[dlv_pin];
  assign dlv_mode      = cfg_dlv_mode[dlv_pin*3 +: 3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr          <= '0;
      delivered    <= '0;
      pend         <= '0;
      remote_irr   <= '0;
      ev_coalesced <= '0;
      ev_masked    <= '0;
      tmr_on       <= 1'b0;
      tmr_cnt      <= '0;
      for (int i = 0; i < NPINS; i++) cnt[i] <= '0;
    end else begin
      ev_coalesced <= '0;
      ev_masked    <= '0;

      if (|storm_hit && (!tmr_on || fire)) begin
        tmr_on  <= 1'b1;
        tmr_cnt <= TMR_W'(DELAY_CYCLES - 1);
      end else if (fire) begin
        tmr_on <= 1'b0;
      end else if (tmr_on) begin
        tmr_cnt <= tmr_cnt - 1'b1;
      end

      if (gnt) begin
        pend[dlv_pin] <= 1'b0;
        if (dlv_level) begin
          if (dlv_hit) remote_irr[dlv_pin] <= 1'b1;
        end else begin
          delivered[dlv_pin] <= 1'b1;
        end
      end

      for (int i = 0; i < NPINS; i++) begin
        if (fire && cfg_trig_level[i] && irr[i] && !remote_irr[i]) begin
          if (cfg_mask[i]) ev_masked[i] <= 1'b1;
          else             pend[i]      <= 1'b1;
        end

        if (line_strobe[i]) begin
          if (!line_level[i]) begin
            irr[i] <= 1'b0;
          end else begin
            irr[i] <= 1'b1;
            if (!cfg_trig_level[i]) delivered[i] <= 1'b0;
            if ((!cfg_trig_level[i] && irr[i]) || (cfg_trig_level[i] && remote_irr[i]))
              ev_coalesced[i] <= 1'b1;
            else if (cfg_mask[i])
              ev_masked[i] <= 1'b1;
            else
              pend[i] <= 1'b1;
          end
        end

        if (eoi_match[i]) begin
          remote_irr[i] <= 1'b0;
          if (storm_hit[i]) begin
            cnt[i] <= '0;
          end else if (eoi_retry[i]) begin
            cnt[i]  <= cnt[i] + 1'b1;
            pend[i] <= 1'b1;
          end else begin
            cnt[i] <= '0;
          end
        end
      end
    end
  end

  assert_storm_arm_on_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(storm_wait) |-> $past(eoi_valid));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    assert_rirr_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_irr[g]) |-> $past(dlv_valid && dlv_ready && dlv_hit && dlv_pin == PIN_W'(g)));
    assert_delivered_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delivered[g]) |-> $past(dlv_valid && dlv_ready && !dlv_level && dlv_pin == PIN_W'(g)));
    assert_cnt_below_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] < CNT_W'(STORM_LIMIT));
  end

endmodule

// File: tb/irq_pin_engine_tb.sv
module irq_pin_engine_tb_top;
  localparam int N = 4, VW = 8, DW = 8, LIM = 4, DLY = 20;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [N-1:0] line_strobe = '0, line_level = '0;
  logic [N*VW-1:0] cfg_vector;
  logic [N*DW-1:0] cfg_dest;
  logic [N-1:0] cfg_dest_mode = '0, cfg_trig_level = '0, cfg_mask = '0;
  logic [N*3-1:0] cfg_dlv_mode = '0;
  logic directed_eoi = 0, eoi_valid = 0, eoi_level = 0, dlv_ready = 0, dlv_hit = 0;
  logic [VW-1:0] eoi_vector = '0;
  logic dlv_valid, dlv_dest_mode, dlv_level, storm_wait;
  logic [1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [DW-1:0] dlv_dest;
  logic [2:0] dlv_mode;
  logic [N-1:0] ev_coalesced, ev_masked, irq_snapshot, remote_irr;

  int checks = 0, errors = 0;

  irq_pin_engine #(.NPINS(N), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)) dut_i (
    .clk, .rst_n, .line_strobe, .line_level, .cfg_vector, .cfg_dest, .cfg_dest_mode,
    .cfg_trig_level, .cfg_dlv_mode, .cfg_mask, .directed_eoi, .eoi_valid, .eoi_vector,
    .eoi_level, .dlv_valid, .dlv_ready, .dlv_hit, .dlv_pin, .dlv_vector, .dlv_dest,
    .dlv_dest_mode, .dlv_level, .dlv_mode, .ev_coalesced, .ev_masked, .irq_snapshot,
    .remote_irr, .storm_wait);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(int p, bit lvl);
    line_strobe[p] = 1; line_level[p] = lvl;
    @(negedge clk);
    line_strobe = '0;
  endtask

  task automatic grant(bit hit);
    dlv_ready = 1; dlv_hit = hit;
    @(negedge clk);
    dlv_ready = 0; dlv_hit = 0;
  endtask

  task automatic eoi(logic [7:0] v, bit lvl);
    eoi_valid = 1; eoi_vector = v; eoi_level = lvl;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic t_reset();
    chk("R12 valid", dlv_valid, 0);
    chk("R12 snapshot", irq_snapshot, 0);
    chk("R12 rirr", remote_irr, 0);
    chk("R12 timer", storm_wait, 0);
  endtask

  task automatic t_edge();
    strobe(0, 1);
    chk("R6 offer", dlv_valid, 1);
    chk("R6 vector", dlv_vector, 8'h20);
    grant(1);
    chk("R6 snapshot hides delivered", irq_snapshot[0], 0);
    chk("R6 no rirr on edge", remote_irr[0], 0);
    strobe(0, 1);
    chk("R2 coalesced", ev_coalesced[0], 1);
    chk("R2 no offer", dlv_valid, 0);
    chk("R6 delivered cleared", irq_snapshot[0], 1);
    strobe(0, 0);
    chk("R1 cleared", irq_snapshot[0], 0);
    strobe(0, 1);
    chk("R2 fresh edge delivers", dlv_valid, 1);
    grant(1);
  endtask

  task automatic t_mask();
    strobe(1, 1);
    chk("R4 masked pulse", ev_masked[1], 1);
    chk("R4 not offered", dlv_valid, 0);
    strobe(1, 0);
  endtask

  task automatic t_order();
    strobe(3, 1);
    strobe(0, 0);
    strobe(0, 1);
    repeat (3) @(negedge clk);
    chk("R11 lowest first", dlv_pin, 0);
    chk("R11 held", dlv_valid, 1);
    grant(1);
    chk("R11 next", dlv_pin, 3);
    grant(1);
    chk("R11 drained", dlv_valid, 0);
  endtask

  task automatic t_level();
    strobe(2, 1);
    chk("R5 offer level", dlv_level, 1);
    grant(0);
    chk("R5 no hit keeps rirr clear", remote_irr[2], 0);
    strobe(2, 1);
    grant(1);
    chk("R5 rirr set", remote_irr[2], 1);
    strobe(2, 1);
    chk("R3 coalesced", ev_coalesced[2], 1);
    chk("R3 no offer", dlv_valid, 0);
    eoi(8'h42, 0);
    chk("R7 edge eoi keeps rirr", remote_irr[2], 1);
    directed_eoi = 1;
    eoi(8'h42, 1);
    directed_eoi = 0;
    chk("R7 directed keeps rirr", remote_irr[2], 1);
    eoi(8'h43, 1);
    chk("R7 other vector keeps rirr", remote_irr[2], 1);
    eoi(8'h42, 1);
    chk("R7 rirr cleared", remote_irr[2], 0);
    chk("R8 redelivered", dlv_valid, 1);
    chk("R8 pin", dlv_pin, 2);
    grant(1);
  endtask

  task automatic t_storm();
    int k;
    eoi(8'h42, 1); grant(1);
    eoi(8'h42, 1); grant(1);
    cfg_mask[3] = 1; cfg_trig_level[3] = 1;
    strobe(3, 1);
    eoi(8'h42, 1);
    chk("R9 no immediate redelivery", dlv_valid, 0);
    chk("R9 timer running", storm_wait, 1);
    cfg_mask[3] = 0;
    k = 0;
    while (!dlv_valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R9 delay", k, DLY);
    chk("R10 pin2 first", dlv_pin, 2);
    grant(1);
    chk("R10 pin3 also serviced", dlv_pin, 3);
    chk("R10 pin3 valid", dlv_valid, 1);
    grant(1);
    chk("R9 timer idle", storm_wait, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      cfg_vector[i*VW +: VW] = 8'h20 + 8'(i);
      cfg_dest[i*DW +: DW] = 8'h10 + 8'(i);
    end
    cfg_vector[2*VW +: VW] = 8'h42;
    cfg_trig_level[2] = 1;
    cfg_mask[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_mask();
    t_order();
    t_level();
    t_storm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule